// File: doc/BRIEF.md
# I2C Slave Stop-Interrupt Qualifier

This block listens to a two-wire serial bus from the target side. It samples the clock and data lines on the system clock through a short synchroniser chain. From those samples it finds START, repeated START and STOP conditions. After every START or repeated START it collects the address byte and compares its upper seven bits with a configured slave address. On a match it pulls the data line low during the ninth clock to acknowledge.

The block keeps a per-transaction record of whether this slave was addressed at any point since the last STOP. When a STOP arrives, that record and a group-command enable input together decide whether a sticky stop-received flag is raised. In group-command mode every STOP raises the flag. This lets a slave that was addressed in the middle of a chain of repeated STARTs act on the single STOP that ends the chain. Software clears the flag with a one-cycle clear pulse.

Top module: `i2c_stop_qualifier`

## Requirements
- R1: After reset, `stop_flag`, `addressed`, `bus_busy` and `sda_oe` are all 0.
- R2: A START (SDA falling while SCL is high) or a repeated START sets `bus_busy`. A STOP (SDA rising while SCL is high) clears it and returns the slave to idle. Both conditions take effect at the third rising clock edge after the SDA transition, given two synchroniser stages.
- R3: The first byte after a START or repeated START is shifted in MSB first on SCL rising edges. Its upper seven bits are compared with `own_addr`, and the last bit (direction) is ignored. On a match, `sda_oe` is 1 from the falling SCL edge after the eighth bit until the falling SCL edge that ends the ninth clock. On a mismatch, `sda_oe` stays 0.
- R4: `addressed` becomes 1 after an address match in any address phase. It stays 1 through later repeated STARTs that carry other addresses, and it is cleared only by a STOP.
- R5: A STOP that ends a transaction in which this slave was addressed sets `stop_flag`, whatever the value of `group_cmd_en`. This includes the case where the slave was addressed only after a repeated START.
- R6: With `group_cmd_en` = 0, a STOP that ends a transaction with no address match leaves `stop_flag` at 0.
- R7: With `group_cmd_en` = 1, every STOP sets `stop_flag`, even if this slave was never addressed.
- R8: `stop_flag` holds its value until a cycle where `stop_flag_clr` = 1 and no STOP is acted on. That cycle clears it.
- R9: When a qualifying STOP is acted on in the same cycle as `stop_flag_clr` = 1, `stop_flag` is 1 afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_in | input | 1 | Bus clock line as seen on the pad |
| sda_in | input | 1 | Bus data line as seen on the pad |
| own_addr | input | 7 | Configured 7-bit slave address |
| group_cmd_en | input | 1 | 1: every STOP raises the flag |
| stop_flag_clr | input | 1 | One-cycle pulse that clears the flag |
| sda_oe | output | 1 | 1: pull the data line low (acknowledge) |
| stop_flag | output | 1 | Sticky stop-received flag |
| addressed | output | 1 | Slave matched in the current transaction |
| bus_busy | output | 1 | A transaction is in progress |

## Verification
The bench runs a group command in which this slave's address appears only after a repeated START, between two foreign addresses. A design that kept only the most recent address phase would drop `addressed` and miss the final STOP. The bench sends unaddressed transactions with group mode off and on. A design that ignored the enable would either raise the flag spuriously or fail to raise it on the group STOP. The bench places a clear pulse on the exact cycle a STOP is acted on. A design that gave the clear priority would lose that STOP. Reads of the own address check that the direction bit does not take part in the match.

// File: rtl/i2c_sq_pkg.sv
package i2c_sq_pkg;

    typedef enum logic [2:0] {
        PH_IDLE     = 3'd0,
        PH_ADDR     = 3'd1,
        PH_ADDR_END = 3'd2,
        PH_ACK      = 3'd3,
        PH_PASS     = 3'd4
    } phase_e;

    // Bus events derived from the synchronised line samples
    typedef struct packed {
        logic start;
        logic stop;
        logic scl_rise;
        logic scl_fall;
        logic sda;
    } bus_ev_t;

endpackage

// File: rtl/i2c_sq_sync.sv
module i2c_sq_sync #(
    parameter int STAGES = 2,
    parameter int WIDTH  = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);

    typedef struct packed {
        logic [STAGES-1:0][WIDTH-1:0] chain;
    } sync_st_t;

    sync_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        for (int s = 0; s < STAGES; s++) begin
            if (s == 0) begin
                st_d.chain[s] = din;
            end else begin
                st_d.chain[s] = st_q.chain[s-1];
            end
        end
    end

    // Idle bus lines are high, so the chain resets to ones
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '1;
        end else begin
            st_q <= st_d;
        end
    end

    assign dout = st_q.chain[STAGES-1];

endmodule

// File: rtl/i2c_sq_cond_det.sv
module i2c_sq_cond_det
    import i2c_sq_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  logic    scl_s,
    input  logic    sda_s,
    output bus_ev_t ev
);

    typedef struct packed {
        logic scl_p;
        logic sda_p;
    } det_st_t;

    det_st_t st_d, st_q;

    always_comb begin
        st_d       = st_q;
        st_d.scl_p = scl_s;
        st_d.sda_p = sda_s;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '1;
        end else begin
            st_q <= st_d;
        end
    end

    // Conditions need SCL high in both samples around the SDA edge
    always_comb begin
        ev.start    = scl_s & st_q.scl_p & st_q.sda_p & ~sda_s;
        ev.stop     = scl_s & st_q.scl_p & ~st_q.sda_p & sda_s;
        ev.scl_rise = scl_s & ~st_q.scl_p;
        ev.scl_fall = ~scl_s & st_q.scl_p;
        ev.sda      = sda_s;
    end

endmodule

// File: rtl/i2c_sq_addr.sv
module i2c_sq_addr
    import i2c_sq_pkg::*;
#(
    parameter int ADDR_W = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  bus_ev_t           ev,
    input  logic [ADDR_W-1:0] own_addr,
    output logic              match_pulse,
    output logic              sda_oe
);

    localparam int BYTE_W = ADDR_W + 1;
    localparam int CNT_W  = $clog2(BYTE_W);

    typedef struct packed {
        phase_e            phase;
        logic [BYTE_W-1:0] shreg;
        logic [CNT_W-1:0]  cnt;
        logic              match_p;
    } addr_st_t;

    addr_st_t st_d, st_q;

    always_comb begin
        st_d         = st_q;
        st_d.match_p = 1'b0;
        if (ev.stop) begin
            st_d.phase = PH_IDLE;
            st_d.cnt   = '0;
        end else if (ev.start) begin
            st_d.phase = PH_ADDR;
            st_d.cnt   = '0;
        end else begin
            case (st_q.phase)
                PH_ADDR: begin
                    if (ev.scl_rise) begin
                        st_d.shreg = {st_q.shreg[BYTE_W-2:0], ev.sda};
                        if (st_q.cnt == CNT_W'(BYTE_W - 1)) begin
                            st_d.phase = PH_ADDR_END;
                            st_d.cnt   = '0;
                        end else begin
                            st_d.cnt = st_q.cnt + 1'b1;
                        end
                    end
                end
                PH_ADDR_END: begin
                    if (ev.scl_fall) begin
                        if (st_q.shreg[BYTE_W-1:1] == own_addr) begin
                            st_d.phase   = PH_ACK;
                            st_d.match_p = 1'b1;
                        end else begin
                            st_d.phase = PH_PASS;
                        end
                    end
                end
                PH_ACK: begin
                    if (ev.scl_fall) begin
                        st_d.phase = PH_PASS;
                    end
                end
                default: st_d.phase = st_q.phase;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.phase   <= PH_IDLE;
            st_q.shreg   <= '0;
            st_q.cnt     <= '0;
            st_q.match_p <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign match_pulse = st_q.match_p;
    assign sda_oe      = (st_q.phase == PH_ACK);

endmodule

// File: rtl/i2c_sq_flag.sv
module i2c_sq_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic start_det,
    input  logic stop_det,
    input  logic match_pulse,
    input  logic group_cmd_en,
    input  logic stop_flag_clr,
    output logic stop_flag,
    output logic addressed,
    output logic bus_busy
);

    typedef struct packed {
        logic busy;
        logic addressed;
        logic flag;
    } flag_st_t;

    flag_st_t st_d, st_q;
    logic     qualify;

    always_comb begin
        st_d    = st_q;
        qualify = st_q.addressed | match_pulse | group_cmd_en;

        if (stop_det) begin
            st_d.busy = 1'b0;
        end else if (start_det) begin
            st_d.busy = 1'b1;
        end

        if (stop_det) begin
            st_d.addressed = 1'b0;
        end else if (match_pulse) begin
            st_d.addressed = 1'b1;
        end

        // A qualifying STOP wins over a clear in the same cycle
        if (stop_det && qualify) begin
            st_d.flag = 1'b1;
        end else if (stop_flag_clr) begin
            st_d.flag = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign stop_flag = st_q.flag;
    assign addressed = st_q.addressed;
    assign bus_busy  = st_q.busy;

endmodule

// File: rtl/i2c_stop_qualifier.sv
module i2c_stop_qualifier
    import i2c_sq_pkg::*;
#(
    parameter int ADDR_W      = 7,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_in,
    input  logic              sda_in,
    input  logic [ADDR_W-1:0] own_addr,
    input  logic              group_cmd_en,
    input  logic              stop_flag_clr,
    output logic              sda_oe,
    output logic              stop_flag,
    output logic              addressed,
    output logic              bus_busy
);

    localparam int LINES = 2;

    logic [LINES-1:0] lines_s;
    bus_ev_t          ev;
    logic             start_det;
    logic             stop_det;
    logic             match_pulse;

    i2c_sq_sync #(
        .STAGES (SYNC_STAGES),
        .WIDTH  (LINES)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   ({scl_in, sda_in}),
        .dout  (lines_s)
    );

    i2c_sq_cond_det u_det (
        .clk   (clk),
        .rst_n (rst_n),
        .scl_s (lines_s[1]),
        .sda_s (lines_s[0]),
        .ev    (ev)
    );

    assign start_det = ev.start;
    assign stop_det  = ev.stop;

    i2c_sq_addr #(
        .ADDR_W (ADDR_W)
    ) u_addr (
        .clk         (clk),
        .rst_n       (rst_n),
        .ev          (ev),
        .own_addr    (own_addr),
        .match_pulse (match_pulse),
        .sda_oe      (sda_oe)
    );

    i2c_sq_flag u_flag (
        .clk           (clk),
        .rst_n         (rst_n),
        .start_det     (start_det),
        .stop_det      (stop_det),
        .match_pulse   (match_pulse),
        .group_cmd_en  (group_cmd_en),
        .stop_flag_clr (stop_flag_clr),
        .stop_flag     (stop_flag),
        .addressed     (addressed),
        .bus_busy      (bus_busy)
    );

endmodule

// File: rtl/i2c_sq_checker.sv
module i2c_sq_checker (
    input logic clk,
    input logic rst_n,
    input logic start_det,
    input logic stop_det,
    input logic match_pulse,
    input logic group_cmd_en,
    input logic stop_flag_clr,
    input logic stop_flag,
    input logic addressed,
    input logic bus_busy,
    input logic sda_oe
);

    p_start_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
        start_det && !stop_det |=> bus_busy);

    p_stop_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
        stop_det |=> !bus_busy && !sda_oe);

    p_ack_in_txn_r3: assert property (@(posedge clk) disable iff (!rst_n)
        sda_oe |-> bus_busy);

    p_match_sets_r4: assert property (@(posedge clk) disable iff (!rst_n)
        match_pulse && !stop_det |=> addressed);

    p_stop_clears_r4: assert property (@(posedge clk) disable iff (!rst_n)
        stop_det |=> !addressed);

    p_addr_stop_r5: assert property (@(posedge clk) disable iff (!rst_n)
        stop_det && addressed |=> stop_flag);

    p_quiet_stop_r6: assert property (@(posedge clk) disable iff (!rst_n)
        stop_det && !addressed && !match_pulse && !group_cmd_en && !stop_flag
        |=> !stop_flag);

    p_group_stop_r7: assert property (@(posedge clk) disable iff (!rst_n)
        stop_det && group_cmd_en |=> stop_flag);

    p_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
        stop_flag_clr && !stop_det |=> !stop_flag);

    p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        stop_flag && !stop_flag_clr |=> stop_flag);

    p_stop_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
        stop_flag_clr && stop_det && (addressed || group_cmd_en) |=> stop_flag);

endmodule

bind i2c_stop_qualifier i2c_sq_checker u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .start_det     (start_det),
    .stop_det      (stop_det),
    .match_pulse   (match_pulse),
    .group_cmd_en  (group_cmd_en),
    .stop_flag_clr (stop_flag_clr),
    .stop_flag     (stop_flag),
    .addressed     (addressed),
    .bus_busy      (bus_busy),
    .sda_oe        (sda_oe)
);

// File: tb/i2c_stop_qualifier_tb.sv
module i2c_stop_qualifier_tb;

    localparam int T        = 10;
    localparam logic [6:0] OWN = 7'h5A;

    typedef enum int { OBS_FLAG, OBS_ADDR, OBS_BUSY, OBS_OE, OBS_ACK } obs_e;

    typedef struct {
        string tag;
        obs_e  sel;
        logic  val;
    } sb_item_t;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic m_scl = 1'b1;
    logic m_sda = 1'b1;
    logic [6:0] own_addr = OWN;
    logic group_cmd_en = 1'b0;
    logic stop_flag_clr = 1'b0;
    logic sda_oe, stop_flag, addressed, bus_busy;
    logic sda_bus;
    logic ack_seen = 1'b0;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;
    sb_item_t sb_q[$];

    always #2 clk = ~clk;

    assign sda_bus = m_sda & ~sda_oe;

    i2c_stop_qualifier u_dut (
        .clk           (clk),
        .rst_n         (rst_n),
        .scl_in        (m_scl),
        .sda_in        (sda_bus),
        .own_addr      (own_addr),
        .group_cmd_en  (group_cmd_en),
        .stop_flag_clr (stop_flag_clr),
        .sda_oe        (sda_oe),
        .stop_flag     (stop_flag),
        .addressed     (addressed),
        .bus_busy      (bus_busy)
    );

    // Monitor: pops expectations and compares with the outputs
    always @(negedge clk) begin
        while (sb_q.size() > 0) begin
            sb_item_t it;
            logic act;
            it = sb_q.pop_front();
            case (it.sel)
                OBS_FLAG: act = stop_flag;
                OBS_ADDR: act = addressed;
                OBS_BUSY: act = bus_busy;
                OBS_OE:   act = sda_oe;
                default:  act = ack_seen;
            endcase
            checks++;
            if (act !== it.val) begin
                fails++;
                $display("FAIL %s: actual=%0b expected=%0b", it.tag, act, it.val);
            end
        end
    end

    task automatic expect_val(input string tag, input obs_e sel, input logic val);
        sb_item_t it;
        it.tag = tag;
        it.sel = sel;
        it.val = val;
        sb_q.push_back(it);
    endtask

    task automatic settle();
        repeat (2) @(negedge clk);
    endtask

    task automatic wt(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_start();
        m_sda = 1'b1; m_scl = 1'b1; wt(T);
        m_sda = 1'b0; wt(T);
        m_scl = 1'b0; wt(T);
    endtask

    task automatic bus_rstart();
        m_scl = 1'b0; m_sda = 1'b1; wt(T);
        m_scl = 1'b1; wt(T);
        m_sda = 1'b0; wt(T);
        m_scl = 1'b0; wt(T);
    endtask

    task automatic bus_stop();
        m_scl = 1'b0; m_sda = 1'b0; wt(T);
        m_scl = 1'b1; wt(T);
        m_sda = 1'b1; wt(T);
    endtask

    task automatic send_byte(input logic [7:0] b);
        for (int i = 7; i >= 0; i--) begin
            m_sda = b[i]; wt(T);
            m_scl = 1'b1; wt(T);
            m_scl = 1'b0; wt(T);
        end
        m_sda = 1'b1; wt(T);
        m_scl = 1'b1; wt(T / 2);
        ack_seen = ~sda_bus;
        wt(T / 2);
        m_scl = 1'b0; wt(T);
    endtask

    task automatic pulse_clr();
        stop_flag_clr = 1'b1; @(negedge clk);
        stop_flag_clr = 1'b0; wt(3);
    endtask

    initial begin
        wt(3);
        expect_val("R1 flag after reset", OBS_FLAG, 1'b0);
        expect_val("R1 addressed after reset", OBS_ADDR, 1'b0);
        expect_val("R1 busy after reset", OBS_BUSY, 1'b0);
        expect_val("R1 sda_oe after reset", OBS_OE, 1'b0);
        settle();
        rst_n = 1'b1;
        wt(5);

        // Addressed write, group mode off
        bus_start();
        expect_val("R2 busy after START", OBS_BUSY, 1'b1);
        settle();
        send_byte({OWN, 1'b0});
        expect_val("R3 ack on matching address", OBS_ACK, 1'b1);
        expect_val("R3 drive released after ninth clock", OBS_OE, 1'b0);
        expect_val("R4 addressed after match", OBS_ADDR, 1'b1);
        settle();
        bus_stop();
        expect_val("R2 idle after STOP", OBS_BUSY, 1'b0);
        expect_val("R4 addressed cleared by STOP", OBS_ADDR, 1'b0);
        expect_val("R5 flag after addressed STOP", OBS_FLAG, 1'b1);
        settle();
        wt(50);
        expect_val("R8 flag held without clear", OBS_FLAG, 1'b1);
        settle();
        pulse_clr();
        expect_val("R8 flag cleared by pulse", OBS_FLAG, 1'b0);
        settle();

        // Foreign address, group mode off
        bus_start();
        send_byte(8'h42);
        expect_val("R3 no ack on mismatch", OBS_ACK, 1'b0);
        expect_val("R4 not addressed on mismatch", OBS_ADDR, 1'b0);
        settle();
        bus_stop();
        expect_val("R6 no flag on unaddressed STOP", OBS_FLAG, 1'b0);
        expect_val("R2 idle after unaddressed STOP", OBS_BUSY, 1'b0);
        settle();

        // Group command without this slave
        group_cmd_en = 1'b1;
        bus_start();
        send_byte(8'h42);
        bus_rstart();
        expect_val("R2 busy after repeated START", OBS_BUSY, 1'b1);
        settle();
        send_byte(8'h66);
        bus_stop();
        expect_val("R7 group STOP flags unaddressed slave", OBS_FLAG, 1'b1);
        expect_val("R4 still unaddressed in group", OBS_ADDR, 1'b0);
        settle();
        pulse_clr();
        expect_val("R8 clear after group STOP", OBS_FLAG, 1'b0);
        settle();

        // Group command with this slave in the middle
        bus_start();
        send_byte(8'h42);
        bus_rstart();
        send_byte({OWN, 1'b0});
        expect_val("R3 ack after repeated START", OBS_ACK, 1'b1);
        settle();
        bus_rstart();
        send_byte(8'h66);
        expect_val("R4 addressed kept over later address", OBS_ADDR, 1'b1);
        expect_val("R3 no ack for later foreign address", OBS_ACK, 1'b0);
        settle();
        bus_stop();
        expect_val("R5 flag at end of group", OBS_FLAG, 1'b1);
        expect_val("R4 cleared at end of group", OBS_ADDR, 1'b0);
        settle();

        // STOP and clear in the same cycle, flag already set
        group_cmd_en = 1'b0;
        bus_start();
        send_byte({OWN, 1'b0});
        m_scl = 1'b0; m_sda = 1'b0; wt(T);
        m_scl = 1'b1; wt(T);
        m_sda = 1'b1;
        @(negedge clk);
        @(negedge clk);
        stop_flag_clr = 1'b1;
        @(negedge clk);
        stop_flag_clr = 1'b0;
        wt(3);
        expect_val("R9 STOP wins over simultaneous clear", OBS_FLAG, 1'b1);
        settle();
        pulse_clr();
        expect_val("R8 clear after R9 case", OBS_FLAG, 1'b0);
        settle();

        // Read direction to own address, after a repeated START
        bus_start();
        send_byte(8'h42);
        bus_rstart();
        send_byte({OWN, 1'b1});
        expect_val("R3 ack ignores direction bit", OBS_ACK, 1'b1);
        settle();
        bus_stop();
        expect_val("R5 flag when addressed after repeated START", OBS_FLAG, 1'b1);
        settle();
        pulse_clr();
        wt(5);

        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            fails++;
            checks++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule